// File: doc/BRIEF.md
# Paired Register Timer Compare Unit

This block is the compare stage of a timer-based capture/compare unit. It holds two compare channels, a primary channel and a secondary channel. Each channel watches one of two free-running timers and signals a match when the timer it watches steps onto that channel's compare value. The primary channel owns an output pin latch that a match can toggle. When the primary channel is in toggle mode and the secondary channel is in interrupt-only mode, the two are paired: a match on either channel toggles the same pin.

Each channel has its own sticky interrupt request flag. A match always sets the flag of the channel that matched. Software clears a flag with a write-one-to-clear strobe. If the pair is not formed, the secondary channel only raises its flag and never touches the pin.

Mode fields are captured into configuration registers on each clock edge, and a synchronous reset sets them to disabled. The compare values are inputs that the block only reads.

Top module: `pair_compare_unit`

## Requirements
- R1: Mode encoding per channel: 2'b00 disabled, 2'b01 interrupt-only, 2'b10 toggle, 2'b11 treated as disabled. A primary channel in toggle mode sets its flag and inverts `pinLatch` on each of its own matches.
- R2: With the primary in toggle mode (2'b10) and the secondary in interrupt-only mode (2'b01), a secondary match sets `flagSec` and inverts `pinLatch`.
- R3: In the paired configuration, if both channels match on the same edge, `pinLatch` inverts exactly once and both `flagPri` and `flagSec` are set.
- R4: When the primary mode is anything other than 2'b10, `pinLatch` holds its value. A secondary match in interrupt-only mode then sets only `flagSec`, and a primary match in interrupt-only mode sets only `flagPri`.
- R5: A channel in mode 2'b00 or 2'b11 never sets its flag. The secondary channel in mode 2'b10 also acts as disabled.
- R6: Each channel picks its timer by its own select bit (0 selects `timer0`, 1 selects `timer1`), independently of the other channel.
- R7: A match occurs only on the edge where the selected timer value equals the compare value and the same timer differed from it on the previous edge. A timer held at the value gives one match. No match occurs on the first edge after reset.
- R8: Flags stay set until their clear input is high on an edge. A match on the same edge as a clear leaves the flag set.
- R9: `pinOe` follows `pinDirOut`. `pinLatch` toggles the same way whatever the direction bit is.
- R10: A synchronous reset clears `pinLatch`, both flags and both captured modes. A mode input takes effect on matches one edge after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timer0 | input | TIMER_W | Free-running timer 0 value |
| timer1 | input | TIMER_W | Free-running timer 1 value |
| cmpPri | input | TIMER_W | Primary compare value |
| cmpSec | input | TIMER_W | Secondary compare value |
| modePri | input | 2 | Primary mode field |
| modeSec | input | 2 | Secondary mode field |
| selPri | input | 1 | Primary timer select |
| selSec | input | 1 | Secondary timer select |
| pinDirOut | input | 1 | Pin direction, 1 = output |
| clrFlagPri | input | 1 | Clear primary flag (write-one) |
| clrFlagSec | input | 1 | Clear secondary flag (write-one) |
| pinLatch | output | 1 | Toggling port latch |
| pinOe | output | 1 | Pin output enable |
| flagPri | output | 1 | Primary interrupt request flag |
| flagSec | output | 1 | Secondary interrupt request flag |

## Verification
The hardest case to reach from the ports is a match on both channels on the same edge while the pair is formed, especially when the channels watch different timers, or when a clear strobe lands on that edge. The bench narrows the timers to four bits and steps them by small random amounts, so both timers keep crossing both compare values. Directed phases set equal compare values, run opposite-direction timers on the two selects, and fire clears on match edges. A bench model follows the timer history, the captured modes and the flags, and predicts every output on every edge.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_IRQ    = 2'b01,
    MODE_TOGGLE = 2'b10,
    MODE_RSVD   = 2'b11
  } cmpMode_t;

  typedef struct packed {
    logic togglePin;
    logic setPri;
    logic setSec;
  } pcuStrobe_t;

  localparam int NUM_CH = 2;
  localparam int CH_PRI = 0;
  localparam int CH_SEC = 1;
endpackage

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TIMER_W-1:0] timer0,
  input  logic [TIMER_W-1:0] timer1,
  input  logic [TIMER_W-1:0] cmpPri,
  input  logic [TIMER_W-1:0] cmpSec,
  input  logic               selPri,
  input  logic               selSec,
  input  logic [1:0]         modePriIn,
  input  logic [1:0]         modeSecIn,
  input  logic               clrPri,
  input  logic               clrSec,
  input  pcuStrobe_t         strobe,
  output logic               hitPri,
  output logic               hitSec,
  output cmpMode_t           modePriQ,
  output cmpMode_t           modeSecQ,
  output logic               pinLatch,
  output logic               flagPri,
  output logic               flagSec
);
  logic [TIMER_W-1:0] prevT0, prevT1;
  logic               prevValid;
  logic [TIMER_W-1:0] cmpArr [NUM_CH];
  logic               selArr [NUM_CH];
  logic [NUM_CH-1:0]  hitVec;

  assign cmpArr[CH_PRI] = cmpPri;
  assign cmpArr[CH_SEC] = cmpSec;
  assign selArr[CH_PRI] = selPri;
  assign selArr[CH_SEC] = selSec;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [TIMER_W-1:0] curT, oldT;
    assign curT = selArr[g] ? timer1 : timer0;
    assign oldT = selArr[g] ? prevT1 : prevT0;
    assign hitVec[g] = prevValid && (curT == cmpArr[g]) && (oldT != cmpArr[g]);
  end

  assign hitPri = hitVec[CH_PRI];
  assign hitSec = hitVec[CH_SEC];

  always_ff @(posedge clk) begin
    if (rst) begin
      prevT0    <= '0;
      prevT1    <= '0;
      prevValid <= 1'b0;
      modePriQ  <= MODE_OFF;
      modeSecQ  <= MODE_OFF;
      pinLatch  <= 1'b0;
      flagPri   <= 1'b0;
      flagSec   <= 1'b0;
    end else begin
      prevT0    <= timer0;
      prevT1    <= timer1;
      prevValid <= 1'b1;
      modePriQ  <= cmpMode_t'(modePriIn);
      modeSecQ  <= cmpMode_t'(modeSecIn);
      if (strobe.togglePin) pinLatch <= ~pinLatch;
      if (strobe.setPri)    flagPri  <= 1'b1;
      else if (clrPri)      flagPri  <= 1'b0;
      if (strobe.setSec)    flagSec  <= 1'b1;
      else if (clrSec)      flagSec  <= 1'b0;
    end
  end
endmodule

// File: rtl/pcu_control.sv
module pcu_control
  import pcu_pkg::*;
(
  input  logic       hitPri,
  input  logic       hitSec,
  input  cmpMode_t   modePri,
  input  cmpMode_t   modeSec,
  output pcuStrobe_t strobe
);
  logic priEnabled, pairOn, secEnabled;

  always_comb begin
    priEnabled = (modePri == MODE_IRQ) || (modePri == MODE_TOGGLE);
    pairOn     = (modePri == MODE_TOGGLE);
    secEnabled = (modeSec == MODE_IRQ);
    strobe.setPri    = hitPri && priEnabled;
    strobe.setSec    = hitSec && secEnabled;
    strobe.togglePin = pairOn && (hitPri || (hitSec && secEnabled));
  end
endmodule

// File: rtl/pair_compare_unit.sv
module pair_compare_unit
  import pcu_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TIMER_W-1:0] timer0,
  input  logic [TIMER_W-1:0] timer1,
  input  logic [TIMER_W-1:0] cmpPri,
  input  logic [TIMER_W-1:0] cmpSec,
  input  logic [1:0]         modePri,
  input  logic [1:0]         modeSec,
  input  logic               selPri,
  input  logic               selSec,
  input  logic               pinDirOut,
  input  logic               clrFlagPri,
  input  logic               clrFlagSec,
  output logic               pinLatch,
  output logic               pinOe,
  output logic               flagPri,
  output logic               flagSec
);
  logic       hitPri, hitSec;
  cmpMode_t   modePriQ, modeSecQ;
  pcuStrobe_t strobe;

  pcu_datapath #(.TIMER_W(TIMER_W)) uDatapath (
    .clk(clk), .rst(rst), .timer0(timer0), .timer1(timer1),
    .cmpPri(cmpPri), .cmpSec(cmpSec), .selPri(selPri), .selSec(selSec),
    .modePriIn(modePri), .modeSecIn(modeSec),
    .clrPri(clrFlagPri), .clrSec(clrFlagSec), .strobe(strobe),
    .hitPri(hitPri), .hitSec(hitSec), .modePriQ(modePriQ), .modeSecQ(modeSecQ),
    .pinLatch(pinLatch), .flagPri(flagPri), .flagSec(flagSec)
  );

  pcu_control uControl (
    .hitPri(hitPri), .hitSec(hitSec), .modePri(modePriQ), .modeSec(modeSecQ),
    .strobe(strobe)
  );

  assign pinOe = pinDirOut;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker (
  input logic       clk,
  input logic       rst,
  input logic       hitPri,
  input logic       hitSec,
  input logic [1:0] modeP,
  input logic [1:0] modeS,
  input logic       clrFlagPri,
  input logic       clrFlagSec,
  input logic       pinLatch,
  input logic       flagPri,
  input logic       flagSec
);
  assert_pri_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    (modeP == 2'b10 && hitPri) |=> (pinLatch != $past(pinLatch) && flagPri));

  assert_pair_sec_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (modeP == 2'b10 && modeS == 2'b01 && hitSec && !hitPri) |=> (pinLatch != $past(pinLatch) && flagSec));

  assert_dual_once_R3: assert property (@(posedge clk) disable iff (rst)
    (modeP == 2'b10 && modeS == 2'b01 && hitPri && hitSec) |=> (pinLatch != $past(pinLatch) && flagPri && flagSec));

  assert_fallback_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (modeP != 2'b10) |=> $stable(pinLatch));

  assert_sec_off_R5: assert property (@(posedge clk) disable iff (rst)
    (modeS != 2'b01 && !flagSec) |=> !flagSec);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clrFlagSec && hitSec && modeS == 2'b01) |=> flagSec);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flagPri && !clrFlagPri) |=> flagPri);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clrFlagPri && !hitPri) |=> !flagPri);
endmodule

bind pair_compare_unit pcu_checker uChecker (
  .clk(clk), .rst(rst), .hitPri(hitPri), .hitSec(hitSec),
  .modeP(modePriQ), .modeS(modeSecQ),
  .clrFlagPri(clrFlagPri), .clrFlagSec(clrFlagSec),
  .pinLatch(pinLatch), .flagPri(flagPri), .flagSec(flagSec)
);

// File: tb/sim_pair_compare_unit.sv
module sim_pair_compare_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] timer0 = '0, timer1 = '0, cmpPri = '0, cmpSec = '0;
  logic [1:0] modePri = 2'b00, modeSec = 2'b00;
  logic selPri = 1'b0, selSec = 1'b0, pinDirOut = 1'b0;
  logic clrFlagPri = 1'b0, clrFlagSec = 1'b0;
  logic pinLatch, pinOe, flagPri, flagSec;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [TW-1:0] mPrev0, mPrev1;
  logic mValid, mLatch, mFlagP, mFlagS;
  logic [1:0] mModeP, mModeS;
  string autoTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_compare_unit #(.TIMER_W(TW)) u0 (
    .clk(clk), .rst(rst), .timer0(timer0), .timer1(timer1),
    .cmpPri(cmpPri), .cmpSec(cmpSec), .modePri(modePri), .modeSec(modeSec),
    .selPri(selPri), .selSec(selSec), .pinDirOut(pinDirOut),
    .clrFlagPri(clrFlagPri), .clrFlagSec(clrFlagSec),
    .pinLatch(pinLatch), .pinOe(pinOe), .flagPri(flagPri), .flagSec(flagSec)
  );

  function automatic logic chanHit(logic sel, logic [TW-1:0] cmp);
    logic [TW-1:0] cur, old;
    cur = sel ? timer1 : timer0;
    old = sel ? mPrev1 : mPrev0;
    return mValid && (cur == cmp) && (old != cmp);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic hp, hs, pair, secEn, priEn;
    string t;
    @(posedge clk);
    autoTag = "R1";
    if (rst) begin
      mPrev0 = '0; mPrev1 = '0; mValid = 0; mLatch = 0; mFlagP = 0; mFlagS = 0;
      mModeP = 2'b00; mModeS = 2'b00;
    end else begin
      hp = chanHit(selPri, cmpPri);
      hs = chanHit(selSec, cmpSec);
      priEn = (mModeP == 2'b01) || (mModeP == 2'b10);
      pair  = (mModeP == 2'b10);
      secEn = (mModeS == 2'b01);
      if (pair && hp && hs && secEn) autoTag = "R3";
      else if (pair && hs && secEn) autoTag = "R2";
      else if (hs && secEn) autoTag = "R4";
      if (pair && (hp || (hs && secEn))) mLatch = ~mLatch;
      if (hp && priEn) mFlagP = 1; else if (clrFlagPri) mFlagP = 0;
      if (hs && secEn) mFlagS = 1; else if (clrFlagSec) mFlagS = 0;
      mPrev0 = timer0; mPrev1 = timer1; mValid = 1;
      mModeP = modePri; mModeS = modeSec;
    end
    @(negedge clk);
    t = (tag == "") ? autoTag : tag;
    chk(t, "pinLatch", pinLatch, mLatch);
    chk(t, "flagPri", flagPri, mFlagP);
    chk(t, "flagSec", flagSec, mFlagS);
    chk(t, "pinOe", pinOe, pinDirOut);
  endtask

  // advance both timers and step; timer1 runs downward
  task automatic runCount(int n, string tag);
    for (int i = 0; i < n; i++) begin
      timer0 = timer0 + 1'b1;
      timer1 = timer1 - 1'b1;
      step(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    // R10: reset state
    rst = 1; step("R10"); step("R10");
    rst = 0;
    // R7: no match on first edge after reset, even if the timer equals cmp
    cmpPri = 4'd0; modePri = 2'b10; step("R7"); step("R7");

    // R1: primary alone in toggle mode
    cmpPri = 4'd5; selPri = 0; pinDirOut = 1;
    runCount(34, "R1");

    // R7: hold timer0 at the compare value
    timer0 = 4'd4; step("R7");
    timer0 = 4'd5; step("R7"); step("R7"); step("R7"); step("R7");

    // R2: paired, secondary matches on a different value
    modeSec = 2'b01; cmpSec = 4'd9; selSec = 0;
    runCount(34, "R2");

    // R3: both match on the same edge
    cmpSec = 4'd5;
    runCount(34, "R3");

    // R6: secondary on timer1 (downward), primary on timer0
    selSec = 1; cmpSec = 4'd11;
    runCount(34, "R6");
    selPri = 1; selSec = 0; cmpPri = 4'd2; cmpSec = 4'd2;
    runCount(34, "R6");

    // R4: fallback, primary interrupt-only, then disabled
    selPri = 0; cmpPri = 4'd3; cmpSec = 4'd8;
    modePri = 2'b01; runCount(34, "R4");
    modePri = 2'b00; runCount(34, "R4");

    // R5: disabled encodings on both channels
    clrFlagPri = 1; clrFlagSec = 1; step("R8"); clrFlagPri = 0; clrFlagSec = 0;
    modePri = 2'b11; modeSec = 2'b11; runCount(34, "R5");
    modePri = 2'b10; modeSec = 2'b10; runCount(34, "R5");

    // R8: clear while matching, clear alone
    modeSec = 2'b01; cmpPri = 4'd7; cmpSec = 4'd7; selSec = 0;
    clrFlagPri = 1; clrFlagSec = 1;
    runCount(20, "R8");
    clrFlagPri = 0; clrFlagSec = 0;
    runCount(5, "R8");

    // R9: direction bit does not change toggling
    pinDirOut = 0; runCount(34, "R9");
    pinDirOut = 1; step("R9");

    // R10: reset mid-run clears latch, flags and captured modes
    rst = 1; step("R10"); rst = 0;
    modePri = 2'b00; modeSec = 2'b00; runCount(20, "R10");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if (i % 60 == 0) begin
        modePri = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b10;
        modeSec = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
        selPri  = 1'($urandom_range(0, 1));
        selSec  = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 40) == 0) cmpPri = TW'($urandom_range(0, 15));
      if ($urandom_range(0, 40) == 0) cmpSec = TW'($urandom_range(0, 15));
      if ($urandom_range(0, 60) == 0) pinDirOut = ~pinDirOut;
      clrFlagPri = ($urandom_range(0, 7) == 0);
      clrFlagSec = ($urandom_range(0, 7) == 0);
      timer0 = timer0 + TW'($urandom_range(0, 2));
      timer1 = timer1 + TW'($urandom_range(0, 3));
      step("");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule